// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces what a byte-wide flash array places on its data bus while an internal program or erase operation runs. Outside such an operation a read returns the array byte supplied on `array_data`. Once an operation starts, a read returns a status byte instead. Bit 7 is a polling bit. It reads as the inverse of the final value while the work is in progress and as the final value once the work is done. Bits 6 to 0 carry a small status word.

The command decoder pulses `op_start` on the rising edge of the last write-enable pulse of a command sequence. With that pulse it presents the operation kind, the target byte and a protected-target flag. An external busy flag marks how long the embedded operation runs, and an erase-suspend flag can pause an erase. A target that is protected does not alter the array. Instead the block holds status for a fixed window, about 2 µs for a program and about 100 µs for an erase. The windows are counted in clock cycles derived from a clock-frequency parameter. After the window the block goes back to array reads.

Top module: `flash_wstat_gen`

## Requirements
- R1: After synchronous active-low reset the block is in array-read mode: with `rd_en`=1 and `oe_n`=0, `dq` equals `array_data`.
- R2: `dq_en` is 1 exactly when `rd_en`=1 and `oe_n`=0. Otherwise `dq_en` is 0 and `dq` is 8'h00.
- R3: `op_start` is taken only in array-read mode. It latches `op_kind` (0 program, 1 erase), `tgt_byte[7]` and `tgt_prot`, and status is shown from the next cycle. A pulse during any status phase is ignored.
- R4: While an unprotected program is busy, `dq[7]` is the inverse of bit 7 of the latched target byte.
- R5: While an unprotected erase is busy and not suspended, `dq[7]` reads 0.
- R6: While an erase is busy, `dq[7]` and `dq[1]` read 1 from the cycle after `erase_susp` is sampled high, for as long as it stays high.
- R7: In every status phase, `dq[0]` is 1 for erase and 0 for program, `dq[1]` is the suspend flag of R6, and `dq[6:2]` are 0.
- R8: Busy sampled low ends an operation. For exactly one cycle `dq[7]` shows the true value (the target bit for a program, 1 for an erase) while `dq[6:0]` still hold status with `dq[1]`=0. In the following cycle the block is back in array-read mode.
- R9: A program to a protected target holds status for CLK_MHZ×PROG_PROT_US cycles, with `dq[7]` inverted as in R4 and `op_busy` ignored, and then returns straight to array reads.
- R10: An erase whose selected sectors are all protected holds status for CLK_MHZ×ERASE_PROT_US cycles, with `dq[7]`=0, and then returns straight to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Pulse on the final write-enable rising edge of a command |
| op_kind | input | 1 | 0 = program, 1 = erase |
| op_busy | input | 1 | Embedded operation still running |
| erase_susp | input | 1 | Erase suspend requested |
| tgt_byte | input | 8 | Byte being programmed |
| tgt_prot | input | 1 | Target protected (for erase: all selected sectors) |
| array_data | input | 8 | Array byte for normal reads |
| rd_en | input | 1 | Read strobe |
| oe_n | input | 1 | Output enable, active low |
| dq | output | 8 | Read data bus |
| dq_en | output | 1 | Bus is driven |

## Verification
On every cycle the assertions check four things: the bus stays quiet while output enable is high, the polling bit has the right polarity during program and erase, the reserved status bits read zero, and the completion phase lasts a single cycle. They also check that a start pulse during an operation leaves the latched command unchanged and that the window counters stay within bounds. Some properties only the bench's scenarios can show. These are the exact lengths of both protected windows, the one-cycle lag of the suspend flag, the true value in the completion cycle and the return to array data afterwards. Those are checked by counting cycles against a bench model over directed and random operations.

// File: rtl/flash_wstat_pkg.sv
// Shared types for the write-status generator.
// Assumes: one operation at a time; phase encoding is internal only.
package flash_wstat_pkg;

    typedef enum logic [2:0] {
        PH_ARRAY = 3'd0,  // normal array reads
        PH_PROG  = 3'd1,  // program running
        PH_ERASE = 3'd2,  // erase running
        PH_DONE  = 3'd3,  // one cycle of true bit 7
        PH_PPROT = 3'd4,  // protected program window
        PH_EPROT = 3'd5   // protected erase window
    } phase_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       susp;
        logic       is_erase;
    } stat_lo_t;

endpackage

// File: rtl/flash_wstat_seq.sv
// Operation sequencer: tracks the phase of the current write operation,
// latches the command, and times the protected-target windows.
// Assumes: op_start is a single-cycle pulse; window lengths are >= 1.
module flash_wstat_seq
    import flash_wstat_pkg::*;
#(
    parameter int PROG_WIN  = 500,
    parameter int ERASE_WIN = 25000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   op_start,
    input  logic   op_kind,
    input  logic   op_busy,
    input  logic   erase_susp,
    input  logic   tgt_bit7,
    input  logic   tgt_prot,
    output phase_t phase,
    output logic   kind_q,
    output logic   tgt7_q,
    output logic   susp_q
);

    localparam int MAX_WIN = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN;
    localparam int CW      = $clog2(MAX_WIN + 1);

    logic [CW-1:0] win_cnt;

    // Phase transitions, command latching and window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_ARRAY;
            win_cnt <= '0;
            kind_q  <= 1'b0;
            tgt7_q  <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            case (phase)
                PH_ARRAY: begin
                    if (op_start) begin
                        kind_q <= op_kind;
                        tgt7_q <= tgt_bit7;
                        susp_q <= 1'b0;
                        if (tgt_prot) begin
                            phase   <= op_kind ? PH_EPROT : PH_PPROT;
                            win_cnt <= op_kind ? CW'(ERASE_WIN - 1) : CW'(PROG_WIN - 1);
                        end else begin
                            phase <= op_kind ? PH_ERASE : PH_PROG;
                        end
                    end
                end
                PH_PROG: begin
                    if (!op_busy) phase <= PH_DONE;
                end
                PH_ERASE: begin
                    if (!op_busy) begin
                        phase  <= PH_DONE;
                        susp_q <= 1'b0;
                    end else begin
                        susp_q <= erase_susp;
                    end
                end
                PH_DONE: phase <= PH_ARRAY;
                PH_PPROT, PH_EPROT: begin
                    if (win_cnt == '0) phase <= PH_ARRAY;
                    else               win_cnt <= win_cnt - 1'b1;
                end
                default: phase <= PH_ARRAY;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DONE |=> phase == PH_ARRAY); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ARRAY && op_start) |=> ($stable(kind_q) && $stable(tgt7_q))); // R3
    AST_PWIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PPROT |-> win_cnt < CW'(PROG_WIN)); // R9
    AST_EWIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EPROT |-> win_cnt < CW'(ERASE_WIN)); // R10
    AST_PPROT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PPROT |=> (phase == PH_PPROT || phase == PH_ARRAY)); // R9

endmodule

// File: rtl/flash_wstat_bus.sv
// Read-bus formatter: selects array data or the status byte and
// gates the bus with the read strobe and output enable.
// Assumes: phase and latched command come from flash_wstat_seq.
module flash_wstat_bus
    import flash_wstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_t     phase,
    input  logic       kind_q,
    input  logic       tgt7_q,
    input  logic       susp_q,
    input  logic [7:0] array_data,
    input  logic       rd_en,
    input  logic       oe_n,
    output logic [7:0] dq,
    output logic       dq_en
);

    logic     poll_bit;
    stat_lo_t stat_lo;
    logic     in_status;

    // Polling bit: inverse of the final value while busy, true value when done.
    always_comb begin
        case (phase)
            PH_PROG:  poll_bit = ~tgt7_q;
            PH_ERASE: poll_bit = susp_q;
            PH_DONE:  poll_bit = kind_q ? 1'b1 : tgt7_q;
            PH_PPROT: poll_bit = ~tgt7_q;
            default:  poll_bit = 1'b0;
        endcase
    end

    // Lower status word and bus selection.
    always_comb begin
        stat_lo.rsvd     = '0;
        stat_lo.susp     = susp_q;
        stat_lo.is_erase = kind_q;
        in_status        = (phase != PH_ARRAY);
        dq_en            = rd_en & ~oe_n;
        if (!dq_en)         dq = 8'h00;
        else if (in_status) dq = {poll_bit, stat_lo};
        else                dq = array_data;
    end

    AST_QUIET_OE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dq == 8'h00 && !dq_en)); // R2
    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG && dq_en) |-> dq[7] == ~tgt7_q); // R4
    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE && !susp_q && dq_en) |-> !dq[7]); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ARRAY && dq_en) |-> dq[6:2] == 5'b0); // R7
    AST_EPROT_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EPROT && dq_en) |-> !dq[7]); // R10

endmodule

// File: rtl/flash_wstat_gen.sv
// Write-status generator top: read data bus of a byte-wide flash array
// while an embedded program or erase runs.
// Assumes: clock frequency in MHz is an integer; windows >= 1 cycle.
module flash_wstat_gen
    import flash_wstat_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int PROG_PROT_US  = 2,
    parameter int ERASE_PROT_US = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       op_kind,
    input  logic       op_busy,
    input  logic       erase_susp,
    input  logic [7:0] tgt_byte,
    input  logic       tgt_prot,
    input  logic [7:0] array_data,
    input  logic       rd_en,
    input  logic       oe_n,
    output logic [7:0] dq,
    output logic       dq_en
);

    localparam int PROG_WIN  = CLK_MHZ * PROG_PROT_US;
    localparam int ERASE_WIN = CLK_MHZ * ERASE_PROT_US;

    phase_t phase;
    logic   kind_q, tgt7_q, susp_q;

    flash_wstat_seq #(
        .PROG_WIN (PROG_WIN),
        .ERASE_WIN(ERASE_WIN)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_busy   (op_busy),
        .erase_susp(erase_susp),
        .tgt_bit7  (tgt_byte[7]),
        .tgt_prot  (tgt_prot),
        .phase     (phase),
        .kind_q    (kind_q),
        .tgt7_q    (tgt7_q),
        .susp_q    (susp_q)
    );

    flash_wstat_bus bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .kind_q    (kind_q),
        .tgt7_q    (tgt7_q),
        .susp_q    (susp_q),
        .array_data(array_data),
        .rd_en     (rd_en),
        .oe_n      (oe_n),
        .dq        (dq),
        .dq_en     (dq_en)
    );

endmodule

// File: tb/flash_wstat_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random operations.
module flash_wstat_gen_tb_top;

    localparam int PWIN = 250 * 2;
    localparam int EWIN = 250 * 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0, op_kind = 1'b0, op_busy = 1'b0, erase_susp = 1'b0;
    logic [7:0] tgt_byte = 8'h00, array_data = 8'h00;
    logic       tgt_prot = 1'b0, rd_en = 1'b0, oe_n = 1'b1;
    logic [7:0] dq;
    logic       dq_en;
    int         tests = 0, fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    flash_wstat_gen dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_busy(op_busy), .erase_susp(erase_susp), .tgt_byte(tgt_byte),
        .tgt_prot(tgt_prot), .array_data(array_data), .rd_en(rd_en),
        .oe_n(oe_n), .dq(dq), .dq_en(dq_en)
    );

    function automatic logic [7:0] busv(logic rd, logic oen, logic [7:0] v);
        return (rd && !oen) ? v : 8'h00;
    endfunction

    function automatic logic [7:0] stat(logic b7, logic susp, logic kind);
        return {b7, 5'b0, susp, kind};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One unprotected operation; busy for busy_n status cycles.
    task automatic run_op(logic kind, logic [7:0] tgt, int busy_n, int susp_at, bit glitch);
        logic es;
        logic [7:0] e;
        string tag;
        rd_en = 1'b1; oe_n = 1'b0; array_data = 8'($urandom);
        #1 chk("R1", dq, array_data);
        op_start = 1'b1; op_kind = kind; tgt_byte = tgt; tgt_prot = 1'b0; op_busy = 1'b1;
        tick();
        op_start = 1'b0; op_kind = ~kind; tgt_byte = ~tgt;
        es = 1'b0;
        for (int c = 0; c < busy_n; c++) begin
            rd_en = 1'($urandom); oe_n = 1'($urandom % 4 == 0); array_data = 8'($urandom);
            if (glitch && c == 0) begin op_start = 1'b1; tgt_prot = 1'b1; end
            #1;
            e = busv(rd_en, oe_n, stat(kind ? es : ~tgt[7], es, kind));
            tag = (glitch && c == 1) ? "R3" : (kind ? (es ? "R6" : "R5") : "R4");
            chk(tag, dq, e);
            chk("R7", dq & 8'h7f, e & 8'h7f);
            chk("R2", {7'b0, dq_en}, {7'b0, rd_en & ~oe_n});
            erase_susp = (susp_at >= 0 && c >= susp_at) ? 1'b1 : 1'b0;
            if (c == busy_n - 1) op_busy = 1'b0;
            tick();
            op_start = 1'b0; tgt_prot = 1'b0;
            es = kind & erase_susp;
        end
        rd_en = 1'b1; oe_n = 1'b0; array_data = 8'($urandom);
        #1 chk("R8", dq, stat(kind ? 1'b1 : tgt[7], 1'b0, kind));
        erase_susp = 1'b0;
        tick();
        chk("R8", dq, array_data);
    endtask

    // Protected target: fixed window, busy ignored.
    task automatic run_prot(logic kind, logic [7:0] tgt);
        int n;
        string tag;
        n = kind ? EWIN : PWIN;
        tag = kind ? "R10" : "R9";
        rd_en = 1'b1; oe_n = 1'b0;
        op_start = 1'b1; op_kind = kind; tgt_byte = tgt; tgt_prot = 1'b1; op_busy = 1'b0;
        tick();
        op_start = 1'b0; tgt_prot = 1'b0; tgt_byte = ~tgt;
        for (int c = 0; c < n; c++) begin
            if (c == 0 || c == n - 1) begin
                array_data = 8'($urandom);
                #1 chk(tag, dq, stat(kind ? 1'b0 : ~tgt[7], 1'b0, kind));
            end
            tick();
        end
        array_data = 8'($urandom);
        #1 chk(tag, dq, array_data);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        rd_en = 1'b1; oe_n = 1'b0; array_data = 8'h5a;
        #1 chk("R1", dq, 8'h5a);
        oe_n = 1'b1;
        #1 chk("R2", dq, 8'h00);
        chk("R2", {7'b0, dq_en}, 8'h00);
        oe_n = 1'b0;
        run_op(1'b0, 8'h80, 3, -1, 1'b0);
        run_op(1'b0, 8'h00, 1, -1, 1'b0);
        run_op(1'b0, 8'h7f, 4, -1, 1'b1);
        run_op(1'b1, 8'h00, 5, 1, 1'b0);
        run_op(1'b1, 8'hff, 3, -1, 1'b1);
        run_prot(1'b0, 8'h80);
        run_prot(1'b0, 8'h01);
        run_prot(1'b1, 8'hff);
        for (int i = 0; i < 40; i++) begin
            logic k;
            k = 1'($urandom);
            run_op(k, 8'($urandom), 1 + int'($urandom % 8),
                   (k && ($urandom % 2 == 1)) ? int'($urandom % 4) : -1,
                   1'($urandom % 3 == 0));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule